// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the privileged-state bookkeeping a processor core needs when it takes a trap. A pipeline stage raises a one-cycle take request carrying a fault type, along with the address of the faulting instruction and the address that would have been fetched next. On the clock edge that samples the request, the block updates four registers it owns: status, cause, exception PC and shadow-register-set control. One cycle later it presents the handler address to which fetch must redirect.

A reset request sends fetch to the fixed reset handler. It only marks coprocessor 1 as usable and leaves the trap bookkeeping alone. Soft reset, non-maskable interrupt and undefined fault codes are not serviced. For these the block raises an unsupported-request flag and changes nothing.

Software reaches the four registers through a whole-word write port and four read-back ports. A trap request in the same cycle takes priority over that port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On a serviced exception, when status bit 1 (EXL) and status bit 22 (BEV) are both 0 before the request, the shadow control register's previous-set field [7:4] receives the old current-set field [3:0], and the current-set field receives the exception-set field [11:8]. All other shadow bits are kept.
- R2: On a serviced exception with EXL or BEV set beforehand, the shadow control register is left unchanged.
- R3: Every serviced exception sets status bit 1 (EXL), whether or not it was already set, and changes no other status bit.
- R4: The instruction is in a delay slot when next PC differs from PC + 4. The exception PC becomes PC − 4 in that case and PC otherwise.
- R5: On a serviced exception the cause register gets bit 31 (BD) = delay-slot flag, bits [29:28] cleared, and bits [6:2] = code. The fault_i encoding and its code are: 0 syscall→8, 1 reserved instruction→10, 2 overflow→12, 3 trap→13, 4 breakpoint→9, 5 machine check→24, 6 coprocessor unusable→11, 7 address error→0, 8 TLB invalid→0, 9 TLB refill→0, 10 TLB modified→1, 11 interrupt→0, 12 reset, 13 soft reset, 14 NMI, and 15 is undefined.
- R6: The handler for fault types 0–10 is base + 0x180. The base is 0xBFC00200 when BEV was 1 before the request and 0x80000000 otherwise.
- R7: The handler for an interrupt (11) is the same base + 0x000.
- R8: A reset request (12) redirects to 0xBFC00000 and sets status bit 29 (CU1). It leaves EXL, cause, exception PC and shadow control unchanged.
- R9: Requests 13, 14 and 15 pulse unsup_o for one cycle, produce no redirect and change no register.
- R10: Register updates appear on the cycle after the request, and redir_valid_o is high in that same cycle only, once per request.
- R11: A software write (sel 0 status, 1 cause, 2 exception PC, 3 shadow control) replaces the whole register on the next cycle. It is discarded if take_i is high in the same cycle.
- R12: After reset, status reads 0x00400000 (BEV = 1), the other three registers read 0, and redir_valid_o and unsup_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | One-cycle trap request |
| fault_i | input | 4 | Fault type (encoding in R5) |
| pc_i | input | 32 | Address of the faulting instruction |
| npc_i | input | 32 | Address that would be fetched next |
| sw_we_i | input | 1 | Software register write enable |
| sw_sel_i | input | 2 | Software register select |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception PC register |
| shadow_o | output | 32 | Shadow-register-set control register |
| redir_valid_o | output | 1 | Redirect strobe |
| redir_addr_o | output | 32 | Handler address, valid with the strobe |
| unsup_o | output | 1 | Unsupported request flag |

## Verification
A software write and a trap request can arrive in the same cycle, and both aim at the same registers. The bench drives a write to the exception PC and a syscall request together. It judges that the stored value is the faulting PC and that the written word is lost. It repeats this with an unsupported request, where the write is also discarded and no register moves, and then makes a plain write in the next cycle to show that the port still works.

// File: rtl/exc_entry_pkg.sv
// Package: shared types and field positions for the exception entry controller.
// Assumes 32-bit registers and a 4-bit fault type encoding.
package exc_entry_pkg;

    // Fault type encoding presented on fault_i
    typedef enum logic [3:0] {
        FLT_SYSCALL  = 4'd0,
        FLT_RSVD     = 4'd1,
        FLT_OVF      = 4'd2,
        FLT_TRAP     = 4'd3,
        FLT_BRK      = 4'd4,
        FLT_MCHK     = 4'd5,
        FLT_CPUNUSE  = 4'd6,
        FLT_ADDRERR  = 4'd7,
        FLT_TLBINV   = 4'd8,
        FLT_TLBMISS  = 4'd9,
        FLT_TLBMOD   = 4'd10,
        FLT_INTR     = 4'd11,
        FLT_RESET    = 4'd12,
        FLT_SRESET   = 4'd13,
        FLT_NMI      = 4'd14,
        FLT_UNDEF    = 4'd15
    } fault_e;

    // How a request is handled
    typedef enum logic [1:0] {
        KIND_EXC   = 2'd0,
        KIND_RESET = 2'd1,
        KIND_UNSUP = 2'd2
    } kind_e;

    // Decoded request
    typedef struct packed {
        kind_e      kind;
        logic       low_vec;   // 1: offset 0x000, 0: general offset
        logic [4:0] code;
    } fault_info_t;

    // Software register select
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_SHADOW = 2'd3
    } sel_e;

    // Status bit positions
    localparam int ST_EXL = 1;
    localparam int ST_BEV = 22;
    localparam int ST_CU1 = 29;

    // Cause field positions
    localparam int CA_BD      = 31;
    localparam int CA_CE_LSB  = 28;
    localparam int CA_CE_W    = 2;
    localparam int CA_CODE_LSB = 2;
    localparam int CA_CODE_W  = 5;

endpackage

// File: rtl/exc_fault_decode.sv
// Module: exc_fault_decode
// Turns a raw fault type into its handling kind, vector class and cause code.
// Assumes the encoding of exc_entry_pkg::fault_e; purely combinational.
module exc_fault_decode
    import exc_entry_pkg::*;
(
    input  logic [3:0]  fault_i,
    output fault_info_t info_o
);

    // Map each fault type to kind, offset class and code
    always_comb begin
        info_o.kind    = KIND_EXC;
        info_o.low_vec = 1'b0;
        info_o.code    = 5'd0;
        case (fault_e'(fault_i))
            FLT_SYSCALL: info_o.code = 5'd8;
            FLT_RSVD:    info_o.code = 5'd10;
            FLT_OVF:     info_o.code = 5'd12;
            FLT_TRAP:    info_o.code = 5'd13;
            FLT_BRK:     info_o.code = 5'd9;
            FLT_MCHK:    info_o.code = 5'd24;
            FLT_CPUNUSE: info_o.code = 5'd11;
            FLT_ADDRERR: info_o.code = 5'd0;
            FLT_TLBINV:  info_o.code = 5'd0;
            FLT_TLBMISS: info_o.code = 5'd0;
            FLT_TLBMOD:  info_o.code = 5'd1;
            FLT_INTR:    info_o.low_vec = 1'b1;
            FLT_RESET: begin
                info_o.kind    = KIND_RESET;
                info_o.low_vec = 1'b1;
            end
            default: begin
                info_o.kind    = KIND_UNSUP;
                info_o.low_vec = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/exc_vector_gen.sv
// Module: exc_vector_gen
// Forms the handler address from the request kind, vector class and BEV.
// Assumes BEV is the value held before the request; combinational.
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [31:0] RUN_BASE   = 32'h8000_0000,
    parameter logic [31:0] GEN_OFFSET = 32'h0000_0180
) (
    input  kind_e       kind_i,
    input  logic        low_vec_i,
    input  logic        bev_i,
    output logic [31:0] addr_o
);

    logic [31:0] base;
    logic [31:0] offset;

    // Choose base and offset, reset overrides both
    always_comb begin
        base   = bev_i ? BOOT_BASE : RUN_BASE;
        offset = low_vec_i ? 32'h0 : GEN_OFFSET;
        addr_o = (kind_i == KIND_RESET) ? RESET_VEC : (base + offset);
    end

endmodule

// File: rtl/exc_csr_file.sv
// Module: exc_csr_file
// Holds status, cause, exception PC and shadow control registers and applies
// the trap-entry updates on the edge that samples take_i.
// Assumes take_i lasts one cycle per request and has priority over software.
module exc_csr_file
    import exc_entry_pkg::*;
#(
    parameter int SET_W       = 4,
    parameter int INSN_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  fault_info_t info_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] npc_i,
    input  logic        sw_we_i,
    input  logic [1:0]  sw_sel_i,
    input  logic [31:0] sw_wdata_i,
    output logic [31:0] status_o,
    output logic [31:0] cause_o,
    output logic [31:0] epc_o,
    output logic [31:0] shadow_o
);

    localparam int CUR_LSB  = 0;
    localparam int PREV_LSB = SET_W;
    localparam int ESS_LSB  = 2 * SET_W;
    localparam logic [31:0] INSN = 32'(INSN_BYTES);
    localparam logic [31:0] STATUS_RST = 32'(1) << ST_BEV;

    logic [31:0] status_q, cause_q, epc_q, shadow_q;
    logic [31:0] status_n, cause_n, epc_n, shadow_n;
    logic        do_exc, do_rst, in_slot, may_rotate;

    assign do_exc     = take_i && (info_i.kind == KIND_EXC);
    assign do_rst     = take_i && (info_i.kind == KIND_RESET);
    assign in_slot    = (npc_i != (pc_i + INSN));
    assign may_rotate = !status_q[ST_EXL] && !status_q[ST_BEV];

    // Next-state: software write first, then trap updates on top
    always_comb begin
        status_n = status_q;
        cause_n  = cause_q;
        epc_n    = epc_q;
        shadow_n = shadow_q;
        if (sw_we_i && !take_i) begin
            case (sel_e'(sw_sel_i))
                SEL_STATUS: status_n = sw_wdata_i;
                SEL_CAUSE:  cause_n  = sw_wdata_i;
                SEL_EPC:    epc_n    = sw_wdata_i;
                default:    shadow_n = sw_wdata_i;
            endcase
        end
        if (do_exc) begin
            if (may_rotate) begin
                shadow_n[PREV_LSB +: SET_W] = shadow_q[CUR_LSB +: SET_W];
                shadow_n[CUR_LSB +: SET_W]  = shadow_q[ESS_LSB +: SET_W];
            end
            status_n[ST_EXL] = 1'b1;
            epc_n = in_slot ? (pc_i - INSN) : pc_i;
            cause_n[CA_BD] = in_slot;
            cause_n[CA_CE_LSB +: CA_CE_W] = '0;
            cause_n[CA_CODE_LSB +: CA_CODE_W] = info_i.code;
        end
        if (do_rst) begin
            status_n[ST_CU1] = 1'b1;
        end
    end

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            cause_q  <= '0;
            epc_q    <= '0;
            shadow_q <= '0;
        end else begin
            status_q <= status_n;
            cause_q  <= cause_n;
            epc_q    <= epc_n;
            shadow_q <= shadow_n;
        end
    end

    assign status_o = status_q;
    assign cause_o  = cause_q;
    assign epc_o    = epc_q;
    assign shadow_o = shadow_q;

    a_r1_shadow_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_EXC && !status_q[ST_EXL] && !status_q[ST_BEV])
        |=> (shadow_q[PREV_LSB +: SET_W] == $past(shadow_q[CUR_LSB +: SET_W]))
         && (shadow_q[CUR_LSB +: SET_W] == $past(shadow_q[ESS_LSB +: SET_W])));

    a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_EXC && (status_q[ST_EXL] || status_q[ST_BEV]))
        |=> $stable(shadow_q));

    a_r3_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_EXC) |=> status_q[ST_EXL]);

    a_r4_epc_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_EXC && npc_i == pc_i + INSN)
        |=> (epc_q == $past(pc_i)));

    a_r8_reset_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_RESET)
        |=> status_q[ST_CU1] && $stable(epc_q) && $stable(cause_q) && $stable(shadow_q));

    a_r9_unsup_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info_i.kind == KIND_UNSUP)
        |=> $stable(status_q) && $stable(cause_q) && $stable(epc_q) && $stable(shadow_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Trap entry controller: decodes the request, updates the privileged
// registers and presents a registered fetch redirect one cycle later.
// Assumes requests are one cycle wide; soft reset and NMI are only flagged.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          SET_W      = 4,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [31:0] RUN_BASE   = 32'h8000_0000,
    parameter logic [31:0] GEN_OFFSET = 32'h0000_0180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic [3:0]  fault_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] npc_i,
    input  logic        sw_we_i,
    input  logic [1:0]  sw_sel_i,
    input  logic [31:0] sw_wdata_i,
    output logic [31:0] status_o,
    output logic [31:0] cause_o,
    output logic [31:0] epc_o,
    output logic [31:0] shadow_o,
    output logic        redir_valid_o,
    output logic [31:0] redir_addr_o,
    output logic        unsup_o
);

    fault_info_t info;
    logic [31:0] vec_addr;
    logic        serviced;

    exc_fault_decode u_decode (
        .fault_i (fault_i),
        .info_o  (info)
    );

    exc_vector_gen #(
        .RESET_VEC  (RESET_VEC),
        .BOOT_BASE  (BOOT_BASE),
        .RUN_BASE   (RUN_BASE),
        .GEN_OFFSET (GEN_OFFSET)
    ) u_vector (
        .kind_i    (info.kind),
        .low_vec_i (info.low_vec),
        .bev_i     (status_o[ST_BEV]),
        .addr_o    (vec_addr)
    );

    exc_csr_file #(
        .SET_W      (SET_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take_i),
        .info_i     (info),
        .pc_i       (pc_i),
        .npc_i      (npc_i),
        .sw_we_i    (sw_we_i),
        .sw_sel_i   (sw_sel_i),
        .sw_wdata_i (sw_wdata_i),
        .status_o   (status_o),
        .cause_o    (cause_o),
        .epc_o      (epc_o),
        .shadow_o   (shadow_o)
    );

    assign serviced = take_i && (info.kind != KIND_UNSUP);

    // Register the redirect strobe, its address and the unsupported flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid_o <= 1'b0;
            redir_addr_o  <= '0;
            unsup_o       <= 1'b0;
        end else begin
            redir_valid_o <= serviced;
            unsup_o       <= take_i && (info.kind == KIND_UNSUP);
            if (serviced) begin
                redir_addr_o <= vec_addr;
            end
        end
    end

    a_r9_unsup_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> !redir_valid_o);

    a_r10_redirect_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> $past(take_i));

    a_r10_reset_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && info.kind == KIND_RESET) |=> (redir_valid_o && redir_addr_o == RESET_VEC));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares at the due cycle.
module exc_entry_ctrl_tb;

    typedef struct packed {
        int          due;
        logic        v;
        logic [31:0] a;
        logic        u;
        logic [31:0] st;
        logic [31:0] ca;
        logic [31:0] ep;
        logic [31:0] sh;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [3:0]  fault_i = '0;
    logic [31:0] pc_i = '0, npc_i = '0;
    logic        sw_we_i = 1'b0;
    logic [1:0]  sw_sel_i = '0;
    logic [31:0] sw_wdata_i = '0;
    logic [31:0] status_o, cause_o, epc_o, shadow_o, redir_addr_o;
    logic        redir_valid_o, unsup_o;

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 0;
    exp_t  q[$];
    string tq[$];
    exp_t  e;
    string t;

    // Bench model of the registers
    logic [31:0] m_st = 32'h0040_0000, m_ca = '0, m_ep = '0, m_sh = '0;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .take_i(take_i), .fault_i(fault_i),
        .pc_i(pc_i), .npc_i(npc_i), .sw_we_i(sw_we_i), .sw_sel_i(sw_sel_i),
        .sw_wdata_i(sw_wdata_i), .status_o(status_o), .cause_o(cause_o),
        .epc_o(epc_o), .shadow_o(shadow_o), .redir_valid_o(redir_valid_o),
        .redir_addr_o(redir_addr_o), .unsup_o(unsup_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] code_of(input logic [3:0] f);
        case (f)
            4'd0: return 5'd8;
            4'd1: return 5'd10;
            4'd2: return 5'd12;
            4'd3: return 5'd13;
            4'd4: return 5'd9;
            4'd5: return 5'd24;
            4'd6: return 5'd11;
            4'd10: return 5'd1;
            default: return 5'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic op(input logic tk, input logic [3:0] f, input logic [31:0] pc,
                      input logic [31:0] npc, input logic we, input logic [1:0] sel,
                      input logic [31:0] wd, input string tag);
        exp_t x;
        logic slot;
        @(negedge clk);
        take_i = tk; fault_i = f; pc_i = pc; npc_i = npc;
        sw_we_i = we; sw_sel_i = sel; sw_wdata_i = wd;
        x = '0;
        x.due = cyc + 1;
        if (tk && f <= 4'd11) begin
            x.v = 1'b1;
            x.a = (m_st[22] ? 32'hBFC0_0200 : 32'h8000_0000) + ((f == 4'd11) ? 32'h0 : 32'h180);
            if (!m_st[1] && !m_st[22])
                m_sh = (m_sh & ~32'hFF) | ((m_sh & 32'hF) << 4) | ((m_sh >> 8) & 32'hF);
            m_st[1] = 1'b1;
            slot = (npc != pc + 32'd4);
            m_ep = slot ? pc - 32'd4 : pc;
            m_ca[31] = slot;
            m_ca[29:28] = 2'b00;
            m_ca[6:2] = code_of(f);
        end else if (tk && f == 4'd12) begin
            x.v = 1'b1;
            x.a = 32'hBFC0_0000;
            m_st[29] = 1'b1;
        end else if (tk) begin
            x.u = 1'b1;
        end else if (we) begin
            case (sel)
                2'd0: m_st = wd;
                2'd1: m_ca = wd;
                2'd2: m_ep = wd;
                default: m_sh = wd;
            endcase
        end
        x.st = m_st; x.ca = m_ca; x.ep = m_ep; x.sh = m_sh;
        q.push_back(x);
        tq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        op(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0, tag);
    endtask

    // Monitor: compare every due item away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            t = tq.pop_front();
            chk(t, "redir_valid", {31'b0, redir_valid_o}, {31'b0, e.v});
            if (e.v) chk(t, "redir_addr", redir_addr_o, e.a);
            chk(t, "unsup", {31'b0, unsup_o}, {31'b0, e.u});
            chk(t, "status", status_o, e.st);
            chk(t, "cause", cause_o, e.ca);
            chk(t, "epc", epc_o, e.ep);
            chk(t, "shadow", shadow_o, e.sh);
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R12 reset state");
        // R11: software writes
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd0, 32'h0000_0000, "R11 write status");
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd1, 32'h3000_0000, "R11 write cause");
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd3, 32'h0000_0503, "R11 write shadow");
        // R1 R3 R4 R5 R6: plain syscall with rotation
        op(1'b1, 4'd0, 32'h1000, 32'h1004, 1'b0, 2'd0, 0, "R1 R3 R4 R5 R6 syscall");
        idle("R10 strobe drops");
        // R2 R4 R5: delay slot with EXL already set
        op(1'b1, 4'd1, 32'h2000, 32'h3000, 1'b0, 2'd0, 0, "R2 R4 R5 delay slot");
        // R6 with BEV set, R2 hold due to BEV
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd0, 32'h0040_0000, "R11 set BEV");
        op(1'b1, 4'd10, 32'h4000, 32'h4004, 1'b0, 2'd0, 0, "R2 R6 TLB modified boot base");
        op(1'b1, 4'd11, 32'h4100, 32'h4104, 1'b0, 2'd0, 0, "R7 interrupt boot base");
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd0, 32'h0000_0000, "R11 clear status");
        op(1'b1, 4'd11, 32'h5000, 32'h5004, 1'b0, 2'd0, 0, "R7 R1 interrupt run base");
        // R5: remaining codes, back to back
        for (int f = 2; f <= 9; f++)
            op(1'b1, 4'(f), 32'h6000 + 32'(f * 16), 32'h6004 + 32'(f * 16), 1'b0, 2'd0, 0, "R5 R10 code table");
        idle("R10 strobe drops after burst");
        // R8: reset request
        op(1'b1, 4'd12, 32'h7000, 32'h9000, 1'b0, 2'd0, 0, "R8 reset request");
        // R9: unsupported requests
        op(1'b1, 4'd13, 32'h7100, 32'h7104, 1'b0, 2'd0, 0, "R9 soft reset");
        op(1'b1, 4'd14, 32'h7200, 32'h7204, 1'b0, 2'd0, 0, "R9 NMI");
        op(1'b1, 4'd15, 32'h7300, 32'h7304, 1'b1, 2'd2, 32'h1111_1111, "R9 R11 undefined with write");
        // R11: collision of write and trap
        op(1'b1, 4'd0, 32'h8000, 32'h8004, 1'b1, 2'd2, 32'hDEAD_0000, "R11 write lost to trap");
        op(1'b0, 4'd0, 0, 0, 1'b1, 2'd2, 32'hCAFE_0004, "R11 plain write after collision");
        idle("R10 final idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule